// File: doc/BRIEF.md
# Endpoint-Zero SETUP Phase Engine for a USB Host

This block carries out the SETUP phase of a host-side control transfer on endpoint zero. Software first sets the target device address and a NAK-limit exponent. It then writes the eight request bytes into a small FIFO and sets two command bits together in a control/status register. The engine then asks an abstract packet layer to send a SETUP token. It streams the eight bytes and waits for the handshake that comes back: ACK, NAK, STALL or no response.

A missing response is retried, up to a fixed number of attempts. A NAK is retried until a programmable number of frame ticks has passed since the transaction began. Every outcome raises one interrupt and leaves status bits for software. After a NAK timeout, software chooses between resuming the same transaction and aborting it by flushing the FIFO. Only the CPU services endpoint zero, so the block has no DMA path.

Registers are selected by `reg_sel`: 0 is the control/status register (CSR), 1 is the device address, 2 is the NAK-limit exponent, and 3 is the FIFO port. A write to select 3 pushes a byte; a read from select 3 returns the byte count. CSR bits: 0 flush (write-only command), 1 transmit-ready, 2 stall received, 3 setup request, 4 error, 7 NAK timeout.

Top module: `usb_ep0_host_engine`

## Requirements
- R1: After reset the CSR reads 0x00, `irq` is low and no token is requested.
- R2: A SETUP phase starts only on a CSR write with bits 3 and 1 both set. A write with only one of them starts nothing and leaves the CSR reading 0x00.
- R3: Each attempt pulses `tok_req` for one cycle with `tok_addr` equal to the address register and `tok_ep` equal to 0. It then presents exactly 8 bytes in FIFO order, with `tx_last` on the eighth.
- R4: A handshake code 3 (no response) is retried. The third consecutive one ends the phase with CSR bit 4 set and bits 1 and 3 cleared.
- R5: A handshake code 2 (STALL) ends the phase at once with CSR bit 2 set, without a retry.
- R6: A handshake code 0 (ACK) ends the phase with CSR 0x00 and an empty FIFO, so a read of select 3 returns 0.
- R7: With a NAK-limit exponent n where 2 ≤ n ≤ 16, a handshake code 1 (NAK) is retried until 2^(n-1) frame ticks have been counted since the transaction began. A NAK after that point sets CSR bit 7 and holds the engine with bits 1 and 3 still set.
- R8: With an exponent outside 2..16, NAKs are retried without limit.
- R9: While held after a NAK timeout, a CSR write with bit 7 clear does one of two things. If the FIFO still holds data and the same write does not flush, the transaction resumes with the frame count restarted. Otherwise the transaction aborts: no token, bits 1 and 3 cleared, and no new interrupt.
- R10: Every phase outcome (ACK, STALL, error, NAK timeout) sets `irq`. It stays set until the CSR is read, and the read clears it.
- R11: An idle CSR write with bits 2 and 4 clear clears the STALL and error status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| frame_tick | input | 1 | One pulse per frame or microframe |
| tok_req | output | 1 | Request to send a SETUP token |
| tok_addr | output | 7 | Target device address |
| tok_ep | output | 4 | Target endpoint, always zero |
| tx_valid | output | 1 | Data byte valid |
| tx_byte | output | 8 | Data byte |
| tx_last | output | 1 | Marks the eighth byte |
| tx_ready | input | 1 | Packet layer accepts the byte |
| hs_valid | input | 1 | Handshake result valid |
| hs_code | input | 2 | 0 ACK, 1 NAK, 2 STALL, 3 no response |
| irq | output | 1 | Endpoint-zero interrupt |

## Verification
A table of handshake scripts drives the main function. Each script is a sequence of response codes paired with a NAK-limit exponent. Single ACK and single STALL rows separate immediate success from immediate refusal. Mixes of missing responses and ACKs show that the retry count stops at exactly three failures and not earlier. NAK runs under limits of 2 and 4 frames, and under out-of-range and large exponents, show where the timeout fires and where it never fires. Directed sequences cover the single-bit writes that must not start, and both ways out of the hold state. The resume case also checks that a NAK right after resuming is retried, which shows the frame count was restarted.

// File: rtl/usb_ep0_pkg.sv
package usb_ep0_pkg;
  typedef enum logic [1:0] {
    HS_ACK   = 2'd0,
    HS_NAK   = 2'd1,
    HS_STALL = 2'd2,
    HS_NONE  = 2'd3
  } hs_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_TOKEN, ST_DATA, ST_WAIT, ST_HOLD
  } st_e;

  localparam int B_FLUSH = 0;
  localparam int B_TXRDY = 1;
  localparam int B_STALL = 2;
  localparam int B_SETUP = 3;
  localparam int B_ERR   = 4;
  localparam int B_NAKTO = 7;

  localparam logic [1:0] SEL_CSR    = 2'd0;
  localparam logic [1:0] SEL_ADDR   = 2'd1;
  localparam logic [1:0] SEL_NAKLIM = 2'd2;
  localparam logic [1:0] SEL_FIFO   = 2'd3;
endpackage

// File: rtl/ep0_fifo.sv
module ep0_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          flush,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic [AW:0]   cnt
);
  logic [DW-1:0] mem [DEPTH];
  logic          accept;

  assign accept  = wr_en && (cnt < (AW+1)'(DEPTH));
  assign rd_data = mem[rd_idx];

  // Storage carries no reset so it maps onto plain memory.
  always_ff @(posedge clk) begin
    if (accept) mem[cnt[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) cnt <= '0;
    else if (accept)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ep0_nak_timer.sv
module ep0_nak_timer #(
  parameter int CW = 16,
  parameter int EW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          run,
  input  logic          tick,
  input  logic [EW-1:0] exp_n,
  output logic          expired
);
  logic [CW:0] count;
  logic [CW:0] limit;
  logic        enabled;

  assign enabled = (exp_n >= EW'(2)) && (exp_n <= EW'(CW));
  assign limit   = enabled ? ((CW+1)'(1) << (exp_n - EW'(1))) : '1;
  assign expired = enabled && (count >= limit);

  always_ff @(posedge clk) begin
    if (rst || restart)              count <= '0;
    else if (run && tick && !(&count)) count <= count + 1'b1;
  end
endmodule

// File: rtl/usb_ep0_host_engine.sv
module usb_ep0_host_engine
  import usb_ep0_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int DW        = 8,
  parameter int PKT_LEN   = 8,
  parameter int MAX_TRIES = 3,
  parameter int NAK_CW    = 16,
  parameter int NAK_EW    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_sel,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              frame_tick,
  output logic              tok_req,
  output logic [ADDR_W-1:0] tok_addr,
  output logic [3:0]        tok_ep,
  output logic              tx_valid,
  output logic [DW-1:0]     tx_byte,
  output logic              tx_last,
  input  logic              tx_ready,
  input  logic              hs_valid,
  input  logic [1:0]        hs_code,
  output logic              irq
);
  localparam int IDXW = $clog2(PKT_LEN);
  localparam int TW   = $clog2(MAX_TRIES + 1);

  st_e               st;
  logic              txrdy_f, setup_f, stall_f, err_f, nakto_f, irq_f;
  logic [ADDR_W-1:0] addr_q;
  logic [NAK_EW-1:0] naklim_q;
  logic [DW-1:0]     rdata_q;
  logic [IDXW-1:0]   byte_idx;
  logic [TW-1:0]     tries;
  logic [IDXW:0]     fifo_cnt;
  logic [DW-1:0]     fifo_q;
  logic              nak_expired;

  logic csr_wr, csr_rd, sw_ok, busy, hs_wait, start, flush, resume_wr, do_resume, ack_done;
  hs_e  hs;

  assign hs        = hs_e'(hs_code);
  assign busy      = (st == ST_TOKEN) || (st == ST_DATA) || (st == ST_WAIT);
  assign hs_wait   = (st == ST_WAIT);
  assign sw_ok     = (st == ST_IDLE) || (st == ST_HOLD);
  assign csr_wr    = reg_wr && (reg_sel == SEL_CSR);
  assign csr_rd    = reg_rd && (reg_sel == SEL_CSR);
  assign start     = csr_wr && (st == ST_IDLE) && reg_wdata[B_SETUP] && reg_wdata[B_TXRDY];
  assign flush     = csr_wr && sw_ok && reg_wdata[B_FLUSH];
  assign resume_wr = csr_wr && (st == ST_HOLD) && !reg_wdata[B_NAKTO];
  assign do_resume = resume_wr && (fifo_cnt != '0) && !reg_wdata[B_FLUSH];
  assign ack_done  = hs_wait && hs_valid && (hs == HS_ACK);

  ep0_fifo #(.DW(DW), .DEPTH(PKT_LEN)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr && (reg_sel == SEL_FIFO) && (st == ST_IDLE)),
    .wr_data (reg_wdata),
    .flush   (flush || ack_done),
    .rd_idx  (byte_idx),
    .rd_data (fifo_q),
    .cnt     (fifo_cnt)
  );

  ep0_nak_timer #(.CW(NAK_CW), .EW(NAK_EW)) u_nak (
    .clk     (clk),
    .rst     (rst),
    .restart (start || do_resume),
    .run     (busy),
    .tick    (frame_tick),
    .exp_n   (naklim_q),
    .expired (nak_expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      txrdy_f  <= 1'b0;
      setup_f  <= 1'b0;
      stall_f  <= 1'b0;
      err_f    <= 1'b0;
      nakto_f  <= 1'b0;
      irq_f    <= 1'b0;
      byte_idx <= '0;
      tries    <= '0;
    end else begin
      if (csr_rd) irq_f <= 1'b0;
      if (csr_wr && sw_ok) begin
        if (!reg_wdata[B_STALL]) stall_f <= 1'b0;
        if (!reg_wdata[B_ERR])   err_f   <= 1'b0;
      end
      case (st)
        ST_IDLE: if (start) begin
          txrdy_f <= 1'b1;
          setup_f <= 1'b1;
          tries   <= '0;
          st      <= ST_TOKEN;
        end
        ST_TOKEN: begin
          byte_idx <= '0;
          st       <= ST_DATA;
        end
        ST_DATA: if (tx_ready) begin
          if (byte_idx == IDXW'(PKT_LEN - 1)) st <= ST_WAIT;
          else byte_idx <= byte_idx + 1'b1;
        end
        ST_WAIT: if (hs_valid) begin
          case (hs)
            HS_ACK: begin
              txrdy_f <= 1'b0; setup_f <= 1'b0; irq_f <= 1'b1; st <= ST_IDLE;
            end
            HS_STALL: begin
              stall_f <= 1'b1;
              txrdy_f <= 1'b0; setup_f <= 1'b0; irq_f <= 1'b1; st <= ST_IDLE;
            end
            HS_NONE: begin
              if (tries == TW'(MAX_TRIES - 1)) begin
                err_f   <= 1'b1;
                txrdy_f <= 1'b0; setup_f <= 1'b0; irq_f <= 1'b1; st <= ST_IDLE;
              end else begin
                tries <= tries + 1'b1;
                st    <= ST_TOKEN;
              end
            end
            default: begin
              if (nak_expired) begin
                nakto_f <= 1'b1; irq_f <= 1'b1; st <= ST_HOLD;
              end else begin
                st <= ST_TOKEN;
              end
            end
          endcase
        end
        ST_HOLD: if (resume_wr) begin
          nakto_f <= 1'b0;
          if (do_resume) begin
            tries <= '0;
            st    <= ST_TOKEN;
          end else begin
            txrdy_f <= 1'b0; setup_f <= 1'b0; st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      naklim_q <= '0;
      rdata_q  <= '0;
    end else begin
      if (reg_wr && !busy && reg_sel == SEL_ADDR)   addr_q   <= reg_wdata[ADDR_W-1:0];
      if (reg_wr && !busy && reg_sel == SEL_NAKLIM) naklim_q <= reg_wdata[NAK_EW-1:0];
      if (reg_rd) begin
        case (reg_sel)
          SEL_CSR:    rdata_q <= {nakto_f, 2'b00, err_f, setup_f, stall_f, txrdy_f, 1'b0};
          SEL_ADDR:   rdata_q <= DW'(addr_q);
          SEL_NAKLIM: rdata_q <= DW'(naklim_q);
          default:    rdata_q <= DW'(fifo_cnt);
        endcase
      end
    end
  end

  assign reg_rdata = rdata_q;
  assign tok_req   = (st == ST_TOKEN);
  assign tok_addr  = addr_q;
  assign tok_ep    = 4'd0;
  assign tx_valid  = (st == ST_DATA);
  assign tx_byte   = fifo_q;
  assign tx_last   = (st == ST_DATA) && (byte_idx == IDXW'(PKT_LEN - 1));
  assign irq       = irq_f;
endmodule

// File: rtl/usb_ep0_host_engine_chk.sv
module usb_ep0_host_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [1:0] reg_sel,
  input logic [7:0] reg_wdata,
  input logic       tok_req,
  input logic       tx_valid,
  input logic       hs_valid,
  input logic [1:0] hs_code,
  input logic       irq,
  input logic       busy,
  input logic       hs_wait,
  input logic       stall_f,
  input logic       err_f
);
  // R2: activity begins only after a CSR write (start, or clearing the timeout bit)
  a_r2_start_from_write: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(reg_wr && reg_sel == 2'd0 &&
                          ((reg_wdata[3] && reg_wdata[1]) || !reg_wdata[7])));

  // R3: a token is followed by the data bytes
  a_r3_token_then_data: assert property (@(posedge clk) disable iff (rst)
    tok_req |=> tx_valid);

  // R3: token and data never overlap
  a_r3_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tok_req, tx_valid}));

  // R4: the error bit only rises after a missing response
  a_r4_err_source: assert property (@(posedge clk) disable iff (rst)
    $rose(err_f) |-> $past(hs_wait && hs_valid && hs_code == 2'd3));

  // R5: STALL ends the phase with status and interrupt
  a_r5_stall_stops: assert property (@(posedge clk) disable iff (rst)
    (hs_wait && hs_valid && hs_code == 2'd2) |=> (stall_f && irq && !busy));

  // R10: reading the CSR clears the interrupt when no outcome lands that cycle
  a_r10_irq_read_clear: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_sel == 2'd0 && !(hs_wait && hs_valid)) |=> !irq);
endmodule

bind usb_ep0_host_engine usb_ep0_host_engine_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata),
  .tok_req   (tok_req),
  .tx_valid  (tx_valid),
  .hs_valid  (hs_valid),
  .hs_code   (hs_code),
  .irq       (irq),
  .busy      (busy),
  .hs_wait   (hs_wait),
  .stall_f   (stall_f),
  .err_f     (err_f)
);

// File: tb/usb_ep0_host_engine_tb.sv
module usb_ep0_host_engine_tb;
  localparam int CLK_P = 10;
  localparam int NROWS = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       frame_tick = 1'b0;
  logic       tok_req;
  logic [6:0] tok_addr;
  logic [3:0] tok_ep;
  logic       tx_valid, tx_last, irq;
  logic [7:0] tx_byte;
  logic       tx_ready = 1'b1;
  logic       hs_valid = 1'b0;
  logic [1:0] hs_code = 2'd0;

  int         n_run = 0, n_fail = 0;
  logic [7:0] byte_base;
  logic [7:0] v;

  always #(CLK_P/2) clk = ~clk;

  usb_ep0_host_engine u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_tick(frame_tick),
    .tok_req(tok_req), .tok_addr(tok_addr), .tok_ep(tok_ep), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .tx_last(tx_last), .tx_ready(tx_ready), .hs_valid(hs_valid),
    .hs_code(hs_code), .irq(irq)
  );

  // {naklim[28:21], codes[20:11] (code k at bits 2k+1:2k), count[10:8], expected CSR[7:0]}
  // codes: 0 ACK, 1 NAK, 2 STALL, 3 no response
  localparam logic [28:0] TBL [NROWS] = '{
    {8'd0,  10'b00_00_00_00_00, 3'd1, 8'h00},  // R6 ACK
    {8'd0,  10'b00_00_00_00_10, 3'd1, 8'h04},  // R5 STALL
    {8'd0,  10'b00_00_11_11_11, 3'd3, 8'h10},  // R4 three misses
    {8'd0,  10'b00_00_00_00_11, 3'd2, 8'h00},  // R4 miss then ACK
    {8'd0,  10'b00_00_00_11_11, 3'd3, 8'h00},  // R4 two misses then ACK
    {8'd2,  10'b00_00_01_01_01, 3'd3, 8'h8A},  // R7 limit 2 frames
    {8'd3,  10'b01_01_01_01_01, 3'd5, 8'h8A},  // R7 limit 4 frames
    {8'd17, 10'b00_01_01_01_01, 3'd5, 8'h00},  // R8 exponent too large
    {8'd1,  10'b00_00_00_01_01, 3'd3, 8'h00},  // R8 exponent too small
    {8'd16, 10'b00_00_00_01_01, 3'd3, 8'h00}   // R7 large limit not reached
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] val);
    reg_rd = 1'b1; reg_sel = s;
    @(negedge clk);
    reg_rd = 1'b0;
    val = reg_rdata;
  endtask

  task automatic load(input logic [7:0] base);
    byte_base = base;
    for (int i = 0; i < 8; i++) wr(2'd3, base + 8'(i));
  endtask

  task automatic wait_tok();
    int cnt = 0;
    while (!tok_req && cnt < 40) begin
      @(negedge clk);
      cnt++;
    end
    chk("R3 token seen", tok_req, 1'b1);
  endtask

  task automatic no_tok(input string tag);
    logic seen = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (tok_req) seen = 1'b1;
    end
    chk(tag, seen, 1'b0);
  endtask

  task automatic respond(input logic [9:0] codes, input int n);
    for (int k = 0; k < n; k++) begin
      wait_tok();
      chk("R3 token address", tok_addr, 7'h2A);
      chk("R3 token endpoint", tok_ep, 4'd0);
      @(negedge clk);
      for (int b = 0; b < 8; b++) begin
        chk("R3 byte valid", tx_valid, 1'b1);
        chk("R3 byte value", tx_byte, byte_base + 8'(b));
        chk("R3 last flag", tx_last, (b == 7));
        @(negedge clk);
      end
      hs_valid   = 1'b1;
      hs_code    = codes[2*k +: 2];
      frame_tick = (codes[2*k +: 2] == 2'd1);
      @(negedge clk);
      hs_valid   = 1'b0;
      frame_tick = 1'b0;
    end
  endtask

  task automatic reach_hold();
    wr(2'd2, 8'd2);
    load(8'hC0);
    wr(2'd0, 8'h0A);
    respond(10'b00_00_01_01_01, 3);
    chk("R7 hold irq", irq, 1'b1);
    rd(2'd0, v);
    chk("R7 hold csr", v, 8'h8A);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq low", irq, 1'b0);
    chk("R1 no token", tok_req, 1'b0);
    rd(2'd0, v);
    chk("R1 csr zero", v, 8'h00);

    wr(2'd1, 8'h2A);

    // R2 single command bits do not start
    load(8'hA0);
    wr(2'd0, 8'h02);
    no_tok("R2 txrdy alone");
    wr(2'd0, 8'h08);
    no_tok("R2 setup alone");
    rd(2'd0, v);
    chk("R2 csr unchanged", v, 8'h00);
    wr(2'd0, 8'h01);

    // Table-driven outcomes
    for (int r = 0; r < NROWS; r++) begin
      wr(2'd2, TBL[r][28:21]);
      load(8'(r * 16));
      wr(2'd0, 8'h0A);
      respond(TBL[r][20:11], int'(TBL[r][10:8]));
      chk("R10 irq on outcome", irq, 1'b1);
      rd(2'd0, v);
      chk("R4 R5 R6 R7 R8 outcome csr", v, TBL[r][7:0]);
      chk("R10 irq cleared by read", irq, 1'b0);
      if (TBL[r][7:0] == 8'h00) begin
        rd(2'd3, v);
        chk("R6 fifo emptied", v, 8'd0);
      end
      wr(2'd0, 8'h01);
      rd(2'd0, v);
      chk("R11 R9 status cleared", v, 8'h00);
    end

    // R9 resume: frame count restarts, so an immediate NAK is retried
    reach_hold();
    wr(2'd0, 8'h00);
    respond(10'b00_00_00_00_01, 1);
    chk("R9 no timeout after resume", irq, 1'b0);
    respond(10'b00_00_00_00_00, 1);
    chk("R9 resume completes irq", irq, 1'b1);
    rd(2'd0, v);
    chk("R9 resume csr", v, 8'h00);

    // R9 abort: flush first, then clear the timeout bit
    reach_hold();
    wr(2'd0, 8'h81);
    rd(2'd0, v);
    chk("R9 timeout kept by flush write", v, 8'h8A);
    wr(2'd0, 8'h00);
    no_tok("R9 abort sends no token");
    chk("R9 abort raises no irq", irq, 1'b0);
    rd(2'd0, v);
    chk("R9 abort csr", v, 8'h00);
    rd(2'd3, v);
    chk("R9 abort fifo empty", v, 8'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule